// File: doc/BRIEF.md
# Block-Copy DMA Engine with On-Device Byte Buffer

This engine copies a run of bytes between host memory and a 4096-byte scratch buffer held inside the block. Software sets up four registers: a source address, a destination address, a byte count, and a command word. Writing the command word with its go bit set starts the copy. Software then polls that same bit, which stays set while the engine runs and clears once the copy is over. A direction bit chooses whether the host side is read or written. Host memory sits behind a byte-wide request/grant port. The buffer appears on the device side as a fixed window beginning at 0x40000.

The engine checks the request once, in the cycle the command is written. It refuses a copy if any byte on the device side would fall outside the window. It also refuses a copy if any host byte would lie at or above 2^HOST_MASK_BITS (28 bits by default). A refused copy returns the go bit to zero and moves nothing. An accepted copy moves one byte for each granted handshake until its remaining count reaches zero. If the command asked for it, the engine then pulses a completion line that signals interrupt value 0x100.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset the source, destination, count and command registers all read 0, `mem_req` is low and `irq_done` is low.
- R2: The registers sit at source 0x80, destination 0x88, count 0x90 and command 0x98. A wide access (`reg_wide`=1) reads or writes all 64 bits. A narrow access uses `reg_wdata[31:0]` and `reg_rdata[31:0]`: `reg_addr[2]`=0 selects the low half and 1 selects the high half, and a narrow write leaves the other half unchanged. Any other offset reads 0.
- R3: Command bit 0 is go, bit 1 is direction and bit 2 is irq enable. With direction 0, the source is a host address and the destination is a device address. Each byte is read from host memory with `mem_we` low, and exactly count handshakes take place.
- R4: With direction 1, the source is a device address and the destination is a host address. Buffer bytes are written to consecutive host addresses with `mem_we` high, one for each handshake.
- R5: Command bit 0 reads 1 from the cycle after an accepted start until the edge after the last handshake, and then reads 0. Bits 1 and 2 keep their written values.
- R6: When bit 2 was set, `irq_done` is high for exactly one cycle, the one right after bit 0 clears. When bit 2 was clear, `irq_done` stays low.
- R7: A start is refused if the device address is below 0x40000 or if the device address plus count is greater than 0x41000. Bit 0 reads 0 right away, no host request is made and the buffer is left untouched.
- R8: A start is refused in the same way if the host address plus count is greater than 2^HOST_MASK_BITS. A copy that ends exactly at that limit is accepted.
- R9: While bit 0 is set, register writes to the source, destination, count and command registers have no effect.
- R10: A start with count 0 is accepted, makes no host request, clears bit 0 one cycle later, and raises `irq_done` if bit 2 is set.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_addr` and `mem_wdata` hold their values and the request stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr`/`reg_wide` |
| mem_req | output | 1 | Host byte request |
| mem_we | output | 1 | 1: host write, 0: host read |
| mem_addr | output | 64 | Host byte address |
| mem_wdata | output | 8 | Byte written to host |
| mem_rdata | input | 8 | Byte read from host, valid in the grant cycle |
| mem_gnt | input | 1 | Grant; a byte moves on each edge where `mem_req` and `mem_gnt` are both high |
| irq_done | output | 1 | One-cycle completion pulse for interrupt value 0x100 |

## Verification
Register reads are combinational, so the bench samples them 1 ns after it sets the address on a falling edge. A command write takes effect on the next rising edge, so bit 0 is already visible at the falling edge that follows. The bench counts each host handshake at the rising edge where it completes. Bit 0 clears on the edge after the final handshake. The completion pulse is high during the cycle after that edge, so the bench lets two more falling edges go by before it compares its handshake and interrupt counts. A monitor compares the address and write data across every wait cycle.

// File: rtl/dma_copy_engine.sv
`timescale 1ns/1ps
module dma_copy_engine #(
  parameter int          HOST_MASK_BITS = 28,
  parameter int          BUF_BYTES      = 4096,
  parameter logic [63:0] WIN_BASE       = 64'h40000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_gnt,
  output logic        irq_done
);
  localparam int          PW       = $clog2(BUF_BYTES);
  localparam logic [63:0] WIN_END  = WIN_BASE + 64'(BUF_BYTES);
  localparam logic [63:0] HOST_LIM = 64'd1 << HOST_MASK_BITS;
  localparam logic [4:0]  SEL_SRC = 5'h10, SEL_DST = 5'h11, SEL_CNT = 5'h12, SEL_CMD = 5'h13;

  logic [63:0] src_q, dst_q, cnt_q, host_ptr, rem;
  logic [2:0]  cmd_q;
  logic [PW-1:0] dev_ptr;
  logic [7:0]  buf_mem [BUF_BYTES];

  wire       busy = cmd_q[0];
  wire [4:0] sel  = reg_addr[7:3];
  wire       hi   = reg_addr[2];

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic wide, input logic upper);
    if (wide)       return wd;
    else if (upper) return {wd[31:0], old[31:0]};
    else            return {old[63:32], wd[31:0]};
  endfunction

  logic [63:0] cmd_full, dev_a, host_a;
  logic [2:0]  new_cmd;
  logic        dev_ok, host_ok, launch_ok;

  always_comb begin
    cmd_full  = merge({61'b0, cmd_q}, reg_wdata, reg_wide, hi);
    new_cmd   = cmd_full[2:0];
    dev_a     = new_cmd[1] ? src_q : dst_q;
    host_a    = new_cmd[1] ? dst_q : src_q;
    dev_ok    = (dev_a >= WIN_BASE) && (dev_a <= WIN_END) && (cnt_q <= WIN_END - dev_a);
    host_ok   = (host_a <= HOST_LIM) && (cnt_q <= HOST_LIM - host_a);
    launch_ok = dev_ok && host_ok;
  end

  wire cmd_wr = reg_wr && !busy && (sel == SEL_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; cmd_q <= '0;
      host_ptr <= '0; rem <= '0; dev_ptr <= '0; irq_done <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      if (!busy && reg_wr) begin
        case (sel)
          SEL_SRC: src_q <= merge(src_q, reg_wdata, reg_wide, hi);
          SEL_DST: dst_q <= merge(dst_q, reg_wdata, reg_wide, hi);
          SEL_CNT: cnt_q <= merge(cnt_q, reg_wdata, reg_wide, hi);
          SEL_CMD: begin
            cmd_q <= {new_cmd[2:1], new_cmd[0] && launch_ok};
            if (new_cmd[0] && launch_ok) begin
              rem      <= cnt_q;
              host_ptr <= host_a;
              dev_ptr  <= PW'(dev_a - WIN_BASE);
            end
          end
          default: ;
        endcase
      end else if (busy) begin
        if (rem == '0) begin
          cmd_q[0] <= 1'b0;
          irq_done <= cmd_q[2];
        end else if (mem_gnt) begin
          rem      <= rem - 64'd1;
          host_ptr <= host_ptr + 64'd1;
          dev_ptr  <= dev_ptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (mem_req && mem_gnt && !cmd_q[1]) buf_mem[dev_ptr] <= mem_rdata;

  assign mem_req   = busy && (rem != '0);
  assign mem_we    = mem_req && cmd_q[1];
  assign mem_addr  = host_ptr;
  assign mem_wdata = buf_mem[dev_ptr];

  logic [63:0] rd_val;
  always_comb begin
    case (sel)
      SEL_SRC: rd_val = src_q;
      SEL_DST: rd_val = dst_q;
      SEL_CNT: rd_val = cnt_q;
      SEL_CMD: rd_val = {61'b0, cmd_q};
      default: rd_val = '0;
    endcase
  end
  assign reg_rdata = reg_wide ? rd_val : {32'b0, hi ? rd_val[63:32] : rd_val[31:0]};

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (rem == $past(rem) - 64'd1));
  p_hold_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  p_host_in_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr < HOST_LIM));
  p_busy_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!busy && $past(busy) && $past(cmd_q[2])));
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && new_cmd[0] && !dev_ok) |=> !busy);
endmodule

// File: tb/test_dma_copy_engine.sv
`timescale 1ns/1ps
module test_dma_copy_engine;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_wide = 1;
  logic [7:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_gnt, irq_done;
  logic [63:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  dma_copy_engine i_dma_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .irq_done(irq_done));

  logic [7:0] hmem [65536];
  logic [7:0] mbuf [4096];
  assign mem_rdata = hmem[mem_addr[15:0]];

  logic gnt_en = 1;
  logic [1:0] ph = 0;
  always @(negedge clk) ph <= ph + 2'd1;
  assign mem_gnt = gnt_en && (ph != 2'd0);

  int hs = 0, irqs = 0, we_bad = 0, hold_bad = 0;
  logic cur_dir = 0;
  logic pw_wait = 0;
  logic [63:0] pa;
  logic [7:0] pd;
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      hs++;
      if (mem_we !== cur_dir) we_bad++;
      if (mem_we) hmem[mem_addr[15:0]] <= mem_wdata;
    end
    if (irq_done) irqs++;
    if (pw_wait && (!mem_req || mem_addr !== pa || (cur_dir && mem_wdata !== pd))) hold_bad++;
    pw_wait <= mem_req && !mem_gnt;
    pa <= mem_addr;
    pd <= mem_wdata;
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wide = wide; reg_wr = 0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output bit timed_out);
    logic [63:0] v;
    timed_out = 1;
    for (int k = 0; k < 3000; k++) begin
      rd(8'h98, 1, v);
      if (!v[0]) begin timed_out = 0; break; end
    end
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic dir; logic ien; logic ok;
    logic [31:0] host; logic [31:0] dev; logic [15:0] cnt;
  } vec_t;
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 32'h0000_0100, 32'h0004_0000, 16'd16},
    '{1'b1, 1'b0, 1'b1, 32'h0000_2000, 32'h0004_0000, 16'd16},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0300, 32'h0004_0FF0, 16'd16},
    '{1'b1, 1'b1, 1'b1, 32'h0000_3000, 32'h0004_0FF0, 16'd16},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0500, 32'h0004_0FF8, 16'd16},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0500, 32'h0003_FFFF, 16'd1},
    '{1'b0, 1'b1, 1'b0, 32'h0FFF_FFF8, 32'h0004_0000, 16'd16},
    '{1'b1, 1'b0, 1'b1, 32'h0FFF_FFF0, 32'h0004_0000, 16'd16},
    '{1'b0, 1'b1, 1'b1, 32'h0000_0100, 32'h0004_0000, 16'd0},
    '{1'b1, 1'b0, 1'b1, 32'h0000_4000, 32'h0004_0000, 16'd16},
    '{1'b1, 1'b1, 1'b1, 32'h0000_5000, 32'h0004_0FF0, 16'd16}
  };

  initial begin
    logic [63:0] v;
    bit to;
    for (int i = 0; i < 65536; i++) hmem[i] = 8'(i * 7 + 1);
    for (int i = 0; i < 4096; i++) mbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(8'h80, 1, v); chk(v == 0, "R1 src after reset", v, 0);
    rd(8'h88, 1, v); chk(v == 0, "R1 dst after reset", v, 0);
    rd(8'h90, 1, v); chk(v == 0, "R1 cnt after reset", v, 0);
    rd(8'h98, 1, v); chk(v == 0, "R1 cmd after reset", v, 0);
    chk(!mem_req && !irq_done, "R1 outputs idle", {mem_req, irq_done}, 0);

    wr(8'h80, 64'h1122_3344_5566_7788, 1);
    rd(8'h80, 0, v); chk(v == 64'h5566_7788, "R2 narrow low", v, 64'h5566_7788);
    rd(8'h84, 0, v); chk(v == 64'h1122_3344, "R2 narrow high", v, 64'h1122_3344);
    wr(8'h84, 64'hAABB_CCDD, 0);
    rd(8'h80, 1, v); chk(v == 64'hAABB_CCDD_5566_7788, "R2 narrow write keeps low half", v, 64'hAABB_CCDD_5566_7788);
    rd(8'h40, 1, v); chk(v == 0, "R2 unmapped offset", v, 0);

    for (int n = 0; n < NV; n++) begin
      vec_t t = VEC[n];
      string tag;
      int exp_hs;
      int bad;
      tag = (t.cnt == 0) ? "R10" : (!t.ok ? "R7/R8" : (t.dir ? "R4" : "R3"));
      cur_dir = t.dir;
      wr(8'h80, t.dir ? 64'(t.dev) : 64'(t.host), 1);
      wr(8'h88, t.dir ? 64'(t.host) : 64'(t.dev), 1);
      wr(8'h90, 64'(t.cnt), 1);
      hs = 0; irqs = 0; we_bad = 0;
      wr(8'h98, {61'b0, t.ien, t.dir, 1'b1}, 1);
      wait_idle(to);
      chk(!to, "R5 go bit clears", to, 0);
      exp_hs = t.ok ? int'(t.cnt) : 0;
      chk(hs == exp_hs, {tag, " handshake count"}, hs, exp_hs);
      chk(we_bad == 0, {tag, " write enable level"}, we_bad, 0);
      chk(irqs == ((t.ok && t.ien) ? 1 : 0), "R6 completion pulses", irqs, (t.ok && t.ien) ? 1 : 0);
      rd(8'h98, 1, v);
      chk(v == {61'b0, t.ien, t.dir, 1'b0}, "R5 command readback", v, {61'b0, t.ien, t.dir, 1'b0});
      if (t.ok && !t.dir)
        for (int i = 0; i < int'(t.cnt); i++)
          mbuf[(t.dev - 32'h40000 + i) & 32'hFFF] = hmem[16'(t.host + i)];
      if (t.ok && t.dir && t.cnt != 0) begin
        bad = 0;
        for (int i = 0; i < int'(t.cnt); i++)
          if (hmem[16'(t.host + i)] !== mbuf[(t.dev - 32'h40000 + i) & 32'hFFF]) bad++;
        chk(bad == 0, "R4 copied bytes (R7 buffer untouched by refusals)", bad, 0);
      end
    end

    cur_dir = 0;
    gnt_en = 0;
    wr(8'h80, 64'h600, 1);
    wr(8'h88, 64'h40100, 1);
    wr(8'h90, 64'd40, 1);
    hs = 0; irqs = 0;
    wr(8'h98, 64'h1, 1);
    rd(8'h98, 1, v); chk(v[0] == 1'b1, "R5 go bit set while running", v, 1);
    wr(8'h80, 64'h777, 1);
    wr(8'h90, 64'd5, 1);
    wr(8'h98, 64'h6, 1);
    rd(8'h80, 1, v); chk(v == 64'h600, "R9 src locked", v, 64'h600);
    rd(8'h90, 1, v); chk(v == 64'd40, "R9 cnt locked", v, 40);
    rd(8'h98, 1, v); chk(v == 64'h1, "R9 cmd locked", v, 1);
    chk(mem_req == 1'b1 && hs == 0, "R11 request held without grant", {mem_req, 8'(hs)}, 9'h100);
    gnt_en = 1;
    wait_idle(to);
    chk(!to && hs == 40, "R9 full original count moved", hs, 40);
    chk(hold_bad == 0, "R11 address and data stable in wait cycles", hold_bad, 0);
    chk(irqs == 0, "R6 no pulse without enable", irqs, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1ms;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule